// File: doc/BRIEF.md
# Memory ECC Error Log Registers

This block sits beside a memory controller's ECC checker and records the first memory error worth reporting. The checker gives one-cycle pulses for correctable errors and for uncorrectable errors. With each pulse it gives the failing physical address, the 8-bit syndrome and the channel number. The block keeps sticky flags for both error kinds. It also keeps one logged record: the 4 KiB block address, the syndrome and the channel. Software reads and writes five registers through a plain indexed register port. It clears flags by writing ones. An interrupt-style error output is high while a flag is set and its enable bit in the command register is set.

The core is a four-state log machine: `LOG_EMPTY`, `LOG_CE`, `LOG_UE` and `LOG_BOTH`.
- `LOG_EMPTY` goes to `LOG_CE` when a correctable error is recorded, and to `LOG_UE` when an uncorrectable error is recorded.
- `LOG_CE` goes to `LOG_BOTH` on an uncorrectable error, and that error overwrites the record.
- `LOG_UE` goes to `LOG_BOTH` on a correctable error, and the record is kept.
- Writing ones to the status register takes a state back toward `LOG_EMPTY`.
- A clear and an event in the same cycle are resolved with the clear first and the event second.

The record is loaded whenever the machine, after that cycle's clear, holds no flag that would protect it.

Top module: `mem_ecc_errlog`

## Requirements
- R1: After reset every flag, both enable bits and every logged field are zero, every register reads zero and `serr_o` is low.
- R2: The status register (index 0) reads bit 0 as the sticky correctable flag and bit 7 as the sticky uncorrectable flag. All other bits read zero. A set flag stays set until it is cleared.
- R3: A write to the status register with bit 0 set clears the correctable flag, and with bit 7 set clears the uncorrectable flag. A zero in either bit leaves that flag unchanged, and all other written bits are ignored.
- R4: The address pointer (index 2) reads bits 31:12 of the logged failing address, with bits 11:0 reading zero.
- R5: The syndrome register (index 3) reads the logged 8-bit syndrome in bits 7:0, with the upper bits zero.
- R6: The channel register (index 4) reads the logged channel in bit 0, with all other bits zero. Indices 5 to 7 read zero.
- R7: A correctable error that arrives while neither flag is set loads the record.
- R8: An uncorrectable error that arrives while the uncorrectable flag is clear loads the record, even when a correctable error is already logged. A correctable error that arrives while the uncorrectable flag is set does not change the record.
- R9: While the correctable flag is set, a further correctable error leaves the record unchanged. While the uncorrectable flag is set, a further uncorrectable error also leaves it unchanged.
- R10: When a clearing write and a new event fall in the same cycle, the event's flag ends up set. The record is then loaded as if the clear had happened first.
- R11: The command register (index 1) keeps bit 7 (enable on correctable) and bit 8 (enable on uncorrectable). All other bits read zero.
- R12: `serr_o` is high exactly while some flag and its enable are both set. It drops in the cycle after the last such pair is cleared.
- R13: A correctable and an uncorrectable error in the same cycle set both flags, and the record holds that cycle's information.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_pulse_i | input | 1 | Correctable error event, one cycle |
| ue_pulse_i | input | 1 | Uncorrectable error event, one cycle |
| ev_addr_i | input | 32 | Failing physical address of the event |
| ev_synd_i | input | 8 | ECC syndrome of the event |
| ev_chan_i | input | 1 | Failing channel of the event |
| reg_addr_i | input | 3 | Register index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the index |
| serr_o | output | 1 | Error signal, level high |

## Verification
A wrong log state shows at the ports in the cycle after the event that caused it, in two places. The status read shows a wrong flag pair. The address, syndrome and channel reads show either a record that should have been protected being overwritten, or a stale record where a fresh one was due. The bench starts from each of the four states and applies every combination of event pair and clear mask in one cycle. Each outcome is compared against arithmetically distinct event data, so a wrong transition or a wrong load decision shows up one cycle later. A wrong enable or flag combination shows on `serr_o` in the cycle after the write or event.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    typedef enum logic [1:0] {
        LOG_EMPTY = 2'b00,
        LOG_CE    = 2'b01,
        LOG_UE    = 2'b10,
        LOG_BOTH  = 2'b11
    } log_state_t;

    typedef enum logic [2:0] {
        RIDX_STATUS = 3'd0,
        RIDX_CMD    = 3'd1,
        RIDX_ADDR   = 3'd2,
        RIDX_SYND   = 3'd3,
        RIDX_CHAN   = 3'd4
    } reg_idx_t;

    localparam int STS_CE_BIT = 0;
    localparam int STS_UE_BIT = 7;
    localparam int CMD_CE_BIT = 7;
    localparam int CMD_UE_BIT = 8;

endpackage

// File: rtl/errlog_fsm.sv
module errlog_fsm
    import errlog_pkg::*;
#(
    parameter int BLK_W = 20,
    parameter int SYN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_pulse_i,
    input  logic             ue_pulse_i,
    input  logic [BLK_W-1:0] ev_blk_i,
    input  logic [SYN_W-1:0] ev_synd_i,
    input  logic             ev_chan_i,
    input  logic             clr_ce_i,
    input  logic             clr_ue_i,
    output logic             ce_flag_o,
    output logic             ue_flag_o,
    output logic [BLK_W-1:0] log_blk_o,
    output logic [SYN_W-1:0] log_synd_o,
    output logic             log_chan_o
);

    log_state_t state_q, state_d;
    logic held_ce, held_ue;
    logic keep_ce, keep_ue;
    logic capture;

    // decode of the current state into flags
    always_comb begin
        held_ce = 1'b0;
        held_ue = 1'b0;
        unique case (state_q)
            LOG_EMPTY: begin held_ce = 1'b0; held_ue = 1'b0; end
            LOG_CE:    begin held_ce = 1'b1; held_ue = 1'b0; end
            LOG_UE:    begin held_ce = 1'b0; held_ue = 1'b1; end
            LOG_BOTH:  begin held_ce = 1'b1; held_ue = 1'b1; end
        endcase
    end

    // clear first, then the event
    always_comb begin
        keep_ce = held_ce & ~clr_ce_i;
        keep_ue = held_ue & ~clr_ue_i;
        if (ue_pulse_i) begin
            capture = ~keep_ue;
        end else begin
            capture = ce_pulse_i & ~keep_ce & ~keep_ue;
        end
        unique case ({keep_ue | ue_pulse_i, keep_ce | ce_pulse_i})
            2'b00: state_d = LOG_EMPTY;
            2'b01: state_d = LOG_CE;
            2'b10: state_d = LOG_UE;
            2'b11: state_d = LOG_BOTH;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LOG_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            log_blk_o  <= '0;
            log_synd_o <= '0;
            log_chan_o <= 1'b0;
        end else if (capture) begin
            log_blk_o  <= ev_blk_i;
            log_synd_o <= ev_synd_i;
            log_chan_o <= ev_chan_i;
        end
    end

    always_comb begin
        ce_flag_o = held_ce;
        ue_flag_o = held_ue;
    end

    AST_UE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ue_flag_o && !clr_ue_i) |=> ue_flag_o); // R2
    AST_CE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_flag_o && !clr_ce_i) |=> ce_flag_o); // R2
    AST_CE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ce_i && !ce_pulse_i) |=> !ce_flag_o); // R3
    AST_UE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ue_i && !ue_pulse_i) |=> !ue_flag_o); // R3
    AST_UE_OVERWRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ue_pulse_i && !ue_flag_o) |=>
        (log_blk_o == $past(ev_blk_i) && log_synd_o == $past(ev_synd_i)
         && log_chan_o == $past(ev_chan_i))); // R8
    AST_UE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ue_flag_o && !clr_ue_i) |=>
        ($stable(log_blk_o) && $stable(log_synd_o) && $stable(log_chan_o))); // R9
    AST_CE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_flag_o && !clr_ce_i && !ue_pulse_i) |=>
        ($stable(log_blk_o) && $stable(log_synd_o) && $stable(log_chan_o))); // R9
    AST_CE_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_pulse_i |=> ce_flag_o); // R10
    AST_UE_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ue_pulse_i |=> ue_flag_o); // R10

endmodule

// File: rtl/errlog_alert.sv
module errlog_alert
    import errlog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_wr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  logic              any_wr_i,
    input  logic              any_ev_i,
    input  logic              ce_flag_i,
    input  logic              ue_flag_i,
    output logic              en_ce_o,
    output logic              en_ue_o,
    output logic              serr_o
);

    logic unused_cmd_bits;

    always_comb begin
        unused_cmd_bits = ^{cmd_wdata_i[DATA_W-1:CMD_UE_BIT+1],
                            cmd_wdata_i[CMD_CE_BIT-1:0]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_ce_o <= 1'b0;
            en_ue_o <= 1'b0;
        end else if (cmd_wr_i) begin
            en_ce_o <= cmd_wdata_i[CMD_CE_BIT];
            en_ue_o <= cmd_wdata_i[CMD_UE_BIT];
        end
    end

    always_comb begin
        serr_o = (ce_flag_i & en_ce_o) | (ue_flag_i & en_ue_o);
    end

    AST_SERR_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(serr_o) |-> $past(any_ev_i || cmd_wr_i)); // R12
    AST_SERR_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(serr_o) |-> $past(any_wr_i)); // R12

endmodule

// File: rtl/errlog_rdmux.sv
module errlog_rdmux
    import errlog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 12,
    parameter int SYN_W     = 8,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        rd_idx_i,
    input  logic              ce_flag_i,
    input  logic              ue_flag_i,
    input  logic              en_ce_i,
    input  logic              en_ue_i,
    input  logic [BLK_W-1:0]  log_blk_i,
    input  logic [SYN_W-1:0]  log_synd_i,
    input  logic              log_chan_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (rd_idx_i)
            RIDX_STATUS: begin
                rdata_o[STS_CE_BIT] = ce_flag_i;
                rdata_o[STS_UE_BIT] = ue_flag_i;
            end
            RIDX_CMD: begin
                rdata_o[CMD_CE_BIT] = en_ce_i;
                rdata_o[CMD_UE_BIT] = en_ue_i;
            end
            RIDX_ADDR: rdata_o[ADDR_W-1:BLK_SHIFT] = log_blk_i;
            RIDX_SYND: rdata_o[SYN_W-1:0] = log_synd_i;
            RIDX_CHAN: rdata_o[0] = log_chan_i;
            default:   rdata_o = '0;
        endcase
    end

    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i == RIDX_STATUS) |->
        (rdata_o[DATA_W-1:8] == '0 && rdata_o[6:1] == '0)); // R2
    AST_ADDR_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i == RIDX_ADDR) |-> (rdata_o[BLK_SHIFT-1:0] == '0)); // R4
    AST_CHAN_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i == RIDX_CHAN) |-> (rdata_o[DATA_W-1:1] == '0)); // R6

endmodule

// File: rtl/mem_ecc_errlog.sv
module mem_ecc_errlog
    import errlog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 12,
    parameter int SYN_W     = 8,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_pulse_i,
    input  logic              ue_pulse_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [SYN_W-1:0]  ev_synd_i,
    input  logic              ev_chan_i,
    input  logic [2:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              serr_o
);

    logic sts_wr, cmd_wr;
    logic clr_ce, clr_ue;
    logic ce_flag, ue_flag;
    logic en_ce, en_ue;
    logic [BLK_W-1:0] log_blk;
    logic [SYN_W-1:0] log_synd;
    logic log_chan;
    logic unused_top_bits;

    always_comb begin
        sts_wr = reg_wr_i && (reg_addr_i == RIDX_STATUS);
        cmd_wr = reg_wr_i && (reg_addr_i == RIDX_CMD);
        clr_ce = sts_wr && reg_wdata_i[STS_CE_BIT];
        clr_ue = sts_wr && reg_wdata_i[STS_UE_BIT];
        unused_top_bits = ^ev_addr_i[BLK_SHIFT-1:0];
    end

    errlog_fsm #(
        .BLK_W (BLK_W),
        .SYN_W (SYN_W)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ce_pulse_i (ce_pulse_i),
        .ue_pulse_i (ue_pulse_i),
        .ev_blk_i   (ev_addr_i[ADDR_W-1:BLK_SHIFT]),
        .ev_synd_i  (ev_synd_i),
        .ev_chan_i  (ev_chan_i),
        .clr_ce_i   (clr_ce),
        .clr_ue_i   (clr_ue),
        .ce_flag_o  (ce_flag),
        .ue_flag_o  (ue_flag),
        .log_blk_o  (log_blk),
        .log_synd_o (log_synd),
        .log_chan_o (log_chan)
    );

    errlog_alert #(
        .DATA_W (DATA_W)
    ) alert_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_wr_i    (cmd_wr),
        .cmd_wdata_i (reg_wdata_i),
        .any_wr_i    (reg_wr_i),
        .any_ev_i    (ce_pulse_i | ue_pulse_i),
        .ce_flag_i   (ce_flag),
        .ue_flag_i   (ue_flag),
        .en_ce_o     (en_ce),
        .en_ue_o     (en_ue),
        .serr_o      (serr_o)
    );

    errlog_rdmux #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT),
        .SYN_W     (SYN_W)
    ) rdmux_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_idx_i   (reg_addr_i),
        .ce_flag_i  (ce_flag),
        .ue_flag_i  (ue_flag),
        .en_ce_i    (en_ce),
        .en_ue_i    (en_ue),
        .log_blk_i  (log_blk),
        .log_synd_i (log_synd),
        .log_chan_i (log_chan),
        .rdata_o    (reg_rdata_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !serr_o); // R1

endmodule

// File: tb/mem_ecc_errlog_tb_top.sv
module mem_ecc_errlog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_p = 1'b0, ue_p = 1'b0;
    logic [31:0] ev_addr = '0;
    logic [7:0]  ev_synd = '0;
    logic        ev_chan = 1'b0;
    logic [2:0]  raddr = '0;
    logic        rwr = 1'b0;
    logic [31:0] rwdata = '0;
    logic [31:0] rrdata;
    logic        serr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int seq = 0;

    // bench-side model
    logic        m_ce, m_ue, m_ence, m_enue;
    logic [31:0] m_addr;
    logic [7:0]  m_synd;
    logic        m_chan;

    always #5 clk = ~clk;

    mem_ecc_errlog dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ce_pulse_i(ce_p), .ue_pulse_i(ue_p),
        .ev_addr_i(ev_addr), .ev_synd_i(ev_synd), .ev_chan_i(ev_chan),
        .reg_addr_i(raddr), .reg_wr_i(rwr), .reg_wdata_i(rwdata),
        .reg_rdata_o(rrdata), .serr_o(serr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        raddr = idx;
        #1;
        v = rrdata;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        ce_p = 0; ue_p = 0; rwr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_ce = 0; m_ue = 0; m_ence = 0; m_enue = 0;
        m_addr = '0; m_synd = '0; m_chan = 0;
    endtask

    // one cycle: events with fresh data plus a status write holding the clear mask
    task automatic step(input logic ce, input logic ue, input logic cc, input logic cu);
        logic kc, ku, cap;
        logic [31:0] a;
        seq++;
        a = 32'h1234_5000 + seq * 32'h0013_57A9;
        ev_addr = a; ev_synd = 8'(seq * 37 + 5); ev_chan = seq[0];
        ce_p = ce; ue_p = ue;
        rwr = 1; raddr = 3'd0;
        rwdata = 32'hFFFF_FF7E | {24'b0, cu, 6'b0, cc};
        kc = m_ce & ~cc; ku = m_ue & ~cu;
        cap = ue ? ~ku : (ce & ~kc & ~ku);
        if (cap) begin
            m_addr = a & 32'hFFFF_F000; m_synd = ev_synd; m_chan = ev_chan;
        end
        m_ce = kc | ce; m_ue = ku | ue;
        @(posedge clk);
        @(negedge clk);
        ce_p = 0; ue_p = 0; rwr = 0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        raddr = idx; rwdata = d; rwr = 1;
        @(posedge clk);
        @(negedge clk);
        rwr = 0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(3'd0, v); check({tag, " R2/R3/R10/R13 status"}, v, {24'b0, m_ue, 6'b0, m_ce});
        rd(3'd2, v); check({tag, " R4/R7/R8/R9 addr"}, v, m_addr);
        rd(3'd3, v); check({tag, " R5/R8/R9 synd"}, v, {24'b0, m_synd});
        rd(3'd4, v); check({tag, " R6/R8 chan"}, v, {31'b0, m_chan});
    endtask

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v); check("R1 reset register", v, 32'h0);
        end
        check("R1 reset serr", {31'b0, serr}, 32'h0);

        // R11 command register bits
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R11 cmd all ones", v, 32'h0000_0180);
        wr(3'd1, 32'h0000_0080); rd(3'd1, v); check("R11 cmd ce only", v, 32'h0000_0080);
        wr(3'd1, 32'h0000_0000); rd(3'd1, v); check("R11 cmd clear", v, 32'h0);

        // sweep: start state x event pair x clear mask
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                for (int c = 0; c < 4; c++) begin
                    do_reset();
                    if (s[0]) step(1'b1, 1'b0, 1'b0, 1'b0);
                    if (s[1]) step(1'b0, 1'b1, 1'b0, 1'b0);
                    step(e[0], e[1], c[0], c[1]);
                    check_all("R7/R8/R9/R10/R13 sweep");
                    check("R12 serr with enables off", {31'b0, serr}, 32'h0);
                end
            end
        end

        // repeated events of the same kind keep the record (R9)
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R9 ce repeat");
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R9 ue repeat");

        // R12 enable x state sweep
        for (int en = 0; en < 4; en++) begin
            for (int s = 0; s < 4; s++) begin
                do_reset();
                wr(3'd1, {23'b0, en[1], en[0], 7'b0});
                if (s[0]) step(1'b1, 1'b0, 1'b0, 1'b0);
                if (s[1]) step(1'b0, 1'b1, 1'b0, 1'b0);
                check("R12 serr level", {31'b0, serr},
                      {31'b0, (s[0] & en[0]) | (s[1] & en[1])});
                wr(3'd1, 32'h0);
                check("R12 serr after disable", {31'b0, serr}, 32'h0);
                wr(3'd1, {23'b0, en[1], en[0], 7'b0});
                wr(3'd0, 32'h0000_0081);
                check("R12 serr after clear", {31'b0, serr}, 32'h0);
                rd(3'd0, v); check("R3 status after clear", v, 32'h0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule